// File: doc/BRIEF.md
# Multicycle Sequencer with Trap Arcs

This block is the hardwired control unit of a processor that spends several clock cycles on each instruction. It steps through fetch, decode, execute, memory access and register write-back for loads, stores, register-register ALU operations, OR with an immediate, branch-on-equal and an unconditional jump. Every control strobe is a Moore output: it depends only on the current step and never on the same-cycle inputs. The datapath that these strobes steer, including the registers A, B, S, M, IR, PC, EPC and Cause, lies outside the block.

The sequencer examines three things. The opcode is examined only in decode. The ALU zero-compare flag is examined only while a branch compares its operands. The ALU overflow flag is examined only while a register-register operation executes. An opcode that no instruction claims, or an overflow on a register-register operation, sends the sequencer to a trap step. That step has the ALU form PC minus 4 for EPC, writes a cause code into bits 5..2 of the Cause word and loads the PC from the fixed handler address. The next fetch therefore comes from the handler. A trap taken on overflow skips the register write.

Top module: `mcyc_seq_ctrl`

## Requirements
- R1: While rst_n is low, and asynchronously on its fall, the sequencer sits in fetch. Fetch drives mem_rd_o=1, mem_adr_sel_o=0 (PC), ir_ld_o=1, alu_a_sel_o=0 (PC), alu_b_sel_o=1 (constant four), alu_fn_o=0 (add), pc_ld_o=1 and pc_src_o=0 (ALU result). Every other strobe is 0.
- R2: Decode always follows fetch and asserts only ab_ld_o. It leaves on the opcode: 6'h00 goes to register-register, 6'h23 to load, 6'h2B to store, 6'h04 to branch, 6'h0D to OR-immediate and 6'h02 to jump.
- R3: A register-register operation executes with alu_a_sel_o=1 (A), alu_b_sel_o=0 (B), alu_fn_o=2 (function field) and s_ld_o=1. If alu_ovf_i is low in that cycle, the next cycle writes back with reg_wr_o=1, reg_dst_sel_o=1 (rd) and reg_wdata_sel_o=0 (S), and fetch follows.
- R4: OR-immediate executes with alu_a_sel_o=1, alu_b_sel_o=4 (zero-extended immediate), alu_fn_o=3 (OR) and s_ld_o=1. It then writes back with reg_wr_o=1, reg_dst_sel_o=0 (rt) and reg_wdata_sel_o=0, and fetch follows.
- R5: A load forms its address with alu_a_sel_o=1, alu_b_sel_o=2 (sign-extended immediate), add and s_ld_o=1. Next it reads with mem_rd_o=1, mem_adr_sel_o=1 (S) and mdr_ld_o=1. Then it writes back with reg_wr_o=1, reg_dst_sel_o=0 and reg_wdata_sel_o=1 (M). Fetch follows.
- R6: A store forms its address the same way as a load, then writes memory with mem_wr_o=1 and mem_adr_sel_o=1, then returns to fetch.
- R7: A branch compares with alu_a_sel_o=1, alu_b_sel_o=0 and alu_fn_o=1 (subtract). If alu_eq_i is high, the next step loads the target with alu_a_sel_o=0, alu_b_sel_o=3 (sign-extended offset shifted left 2), add, pc_ld_o=1 and pc_src_o=0, then goes to fetch. If alu_eq_i is low, fetch follows directly.
- R8: A jump takes one step with pc_ld_o=1 and pc_src_o=1 (jump address), then goes to fetch.
- R9: Any other opcode in decode leads to a trap step. That step drives alu_a_sel_o=0, alu_b_sel_o=1, alu_fn_o=1 (PC minus 4), epc_wr_o=1, cause_wr_o=1, cause_val_o=10<<2 (32'h28), pc_ld_o=1 and pc_src_o=2 (handler vector), then goes to fetch. exc_vec_o is always 32'h8000_0080.
- R10: Overflow during register-register execute leads to the same trap step pattern but with cause_val_o=12<<2 (32'h30). No write-back step with reg_wr_o=1 follows; fetch is next.
- R11: alu_eq_i has no effect outside the branch compare, alu_ovf_i has no effect outside register-register execute, and opcode_i has no effect outside decode.
- R12: mem_rd_o and mem_wr_o are never high together, and cause_val_o is zero whenever cause_wr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | OP_W | Opcode field of the instruction register |
| alu_eq_i | input | 1 | ALU result is zero |
| alu_ovf_i | input | 1 | ALU signed overflow |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_adr_sel_o | output | 1 | Memory address: 0 PC, 1 S |
| ir_ld_o | output | 1 | Load instruction register |
| ab_ld_o | output | 1 | Load operand registers A and B |
| s_ld_o | output | 1 | Load ALU result register S |
| mdr_ld_o | output | 1 | Load memory data register M |
| alu_a_sel_o | output | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel_o | output | 3 | ALU second operand: 0 B, 1 four, 2 sext, 3 sext<<2, 4 zext |
| alu_fn_o | output | 2 | ALU function: 0 add, 1 sub, 2 funct, 3 or |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_sel_o | output | 1 | Destination: 0 rt, 1 rd |
| reg_wdata_sel_o | output | 1 | Write data: 0 S, 1 M |
| pc_ld_o | output | 1 | Load PC |
| pc_src_o | output | 2 | PC source: 0 ALU, 1 jump address, 2 handler vector |
| epc_wr_o | output | 1 | Write EPC from the ALU result |
| cause_wr_o | output | 1 | Write Cause |
| cause_val_o | output | CAUSE_W | Cause word with the code in bits 5..2 |
| exc_vec_o | output | ADDR_W | Handler address |

## Verification
Two pairs of events can fall in the same cycle. The first is the ALU overflow flag and the zero flag together in register-register execute. The second is the two flags together during a branch compare, since a subtraction can overflow. The bench raises both flags at once for whole instructions. It also scrambles the opcode outside decode, so each case shows whether the step follows only its own flag. A per-cycle reference model predicts every strobe. An overflowed register operation must show the trap step with cause 32'h30 and no write cycle, and a compare that overflows with equal operands must still take the branch.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   localparam int unsigned STATE_W    = 4;
   localparam int unsigned NUM_STATES = 1 << STATE_W;

   typedef enum logic [STATE_W-1:0] {
      ST_FETCH    = 4'd0,
      ST_DECODE   = 4'd1,
      ST_BR_CMP   = 4'd2,
      ST_BR_TAKE  = 4'd3,
      ST_RR_EXE   = 4'd4,
      ST_RR_WB    = 4'd5,
      ST_OI_EXE   = 4'd6,
      ST_OI_WB    = 4'd7,
      ST_LD_ADR   = 4'd8,
      ST_LD_MEM   = 4'd9,
      ST_LD_WB    = 4'd10,
      ST_ST_ADR   = 4'd11,
      ST_ST_MEM   = 4'd12,
      ST_TRAP_UND = 4'd13,
      ST_TRAP_OVF = 4'd14,
      ST_JUMP     = 4'd15
   } seq_state_e;

   typedef enum logic [2:0] {
      CLS_RR  = 3'd0,
      CLS_LD  = 3'd1,
      CLS_ST  = 3'd2,
      CLS_BR  = 3'd3,
      CLS_OI  = 3'd4,
      CLS_JMP = 3'd5,
      CLS_BAD = 3'd6
   } op_class_e;

   typedef enum logic [1:0] {
      FN_ADD   = 2'd0,
      FN_SUB   = 2'd1,
      FN_FUNCT = 2'd2,
      FN_OR    = 2'd3
   } alu_fn_e;

   typedef enum logic [2:0] {
      BSEL_REG     = 3'd0,
      BSEL_FOUR    = 3'd1,
      BSEL_SEXT    = 3'd2,
      BSEL_SEXT_SH = 3'd3,
      BSEL_ZEXT    = 3'd4
   } bsel_e;

   typedef enum logic [1:0] {
      PCS_ALU  = 2'd0,
      PCS_JUMP = 2'd1,
      PCS_VEC  = 2'd2
   } pc_src_e;

   typedef struct packed {
      logic    mem_rd;
      logic    mem_wr;
      logic    mem_adr_s;
      logic    ir_ld;
      logic    ab_ld;
      logic    s_ld;
      logic    m_ld;
      logic    a_from_reg;
      bsel_e   bsel;
      alu_fn_e fn;
      logic    rf_wr;
      logic    rf_dst_rd;
      logic    rf_from_m;
      logic    pc_ld;
      pc_src_e pc_src;
      logic    epc_wr;
      logic    cause_wr;
      logic    trap_ovf;
   } ctrl_t;

endpackage

// File: rtl/mcyc_op_classify.sv
module mcyc_op_classify
   import mcyc_pkg::*;
#(
   parameter int unsigned          OP_W     = 6,
   parameter logic [OP_W-1:0]      OP_RTYPE = 6'h00,
   parameter logic [OP_W-1:0]      OP_LW    = 6'h23,
   parameter logic [OP_W-1:0]      OP_SW    = 6'h2B,
   parameter logic [OP_W-1:0]      OP_BEQ   = 6'h04,
   parameter logic [OP_W-1:0]      OP_ORI   = 6'h0D,
   parameter logic [OP_W-1:0]      OP_JMP   = 6'h02
) (
   input  logic [OP_W-1:0] opcode,
   output op_class_e       op_class
);

   localparam int unsigned N_KNOWN = 6;

   logic      [OP_W-1:0] known_op  [N_KNOWN];
   op_class_e            known_cls [N_KNOWN];
   logic [N_KNOWN-1:0]   hit;

   always_comb begin
      known_op[0]  = OP_RTYPE; known_cls[0] = CLS_RR;
      known_op[1]  = OP_LW;    known_cls[1] = CLS_LD;
      known_op[2]  = OP_SW;    known_cls[2] = CLS_ST;
      known_op[3]  = OP_BEQ;   known_cls[3] = CLS_BR;
      known_op[4]  = OP_ORI;   known_cls[4] = CLS_OI;
      known_op[5]  = OP_JMP;   known_cls[5] = CLS_JMP;
   end

   for (genvar g = 0; g < N_KNOWN; g++) begin : g_match
      assign hit[g] = (opcode == known_op[g]);
   end

   always_comb begin
      op_class = CLS_BAD;
      for (int i = N_KNOWN - 1; i >= 0; i--) begin
         if (hit[i]) op_class = known_cls[i];
      end
   end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
   import mcyc_pkg::*;
(
   input  seq_state_e cur,
   input  op_class_e  op_class,
   input  logic       alu_eq,
   input  logic       alu_ovf,
   output seq_state_e nxt
);

   seq_state_e dispatch;

   always_comb begin
      unique case (op_class)
         CLS_RR:  dispatch = ST_RR_EXE;
         CLS_LD:  dispatch = ST_LD_ADR;
         CLS_ST:  dispatch = ST_ST_ADR;
         CLS_BR:  dispatch = ST_BR_CMP;
         CLS_OI:  dispatch = ST_OI_EXE;
         CLS_JMP: dispatch = ST_JUMP;
         default: dispatch = ST_TRAP_UND;
      endcase
   end

   always_comb begin
      nxt = ST_FETCH;
      unique case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = dispatch;
         ST_BR_CMP: nxt = alu_eq  ? ST_BR_TAKE  : ST_FETCH;
         ST_RR_EXE: nxt = alu_ovf ? ST_TRAP_OVF : ST_RR_WB;
         ST_OI_EXE: nxt = ST_OI_WB;
         ST_LD_ADR: nxt = ST_LD_MEM;
         ST_LD_MEM: nxt = ST_LD_WB;
         ST_ST_ADR: nxt = ST_ST_MEM;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcyc_state_store.sv
module mcyc_state_store
   import mcyc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e nxt,
   output seq_state_e cur
);

   if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] hot_q;
      logic [NUM_STATES-1:0] hot_d;
      logic [STATE_W-1:0]    idx;

      always_comb begin
         hot_d = '0;
         hot_d[nxt] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hot_q <= NUM_STATES'(1);
         else        hot_q <= hot_d;
      end

      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_STATES; i++) begin
            if (hot_q[i]) idx = idx | STATE_W'(i);
         end
      end

      assign cur = seq_state_e'(idx);
   end else begin : g_binary
      seq_state_e st_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= ST_FETCH;
         else        st_q <= nxt;
      end

      assign cur = st_q;
   end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
   import mcyc_pkg::*;
#(
   parameter int unsigned CAUSE_W    = 32,
   parameter int unsigned CODE_LSB   = 2,
   parameter int unsigned CODE_UNDEF = 10,
   parameter int unsigned CODE_OVF   = 12
) (
   input  seq_state_e         cur,
   output ctrl_t              ctrl,
   output logic [CAUSE_W-1:0] cause_val
);

   localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(CODE_UNDEF) << CODE_LSB;
   localparam logic [CAUSE_W-1:0] CAUSE_OVF   = CAUSE_W'(CODE_OVF)   << CODE_LSB;

   always_comb begin
      ctrl = '0;
      unique case (cur)
         ST_FETCH: begin
            ctrl.mem_rd = 1'b1;
            ctrl.ir_ld  = 1'b1;
            ctrl.bsel   = BSEL_FOUR;
            ctrl.fn     = FN_ADD;
            ctrl.pc_ld  = 1'b1;
            ctrl.pc_src = PCS_ALU;
         end
         ST_DECODE: begin
            ctrl.ab_ld = 1'b1;
         end
         ST_BR_CMP: begin
            ctrl.a_from_reg = 1'b1;
            ctrl.bsel       = BSEL_REG;
            ctrl.fn         = FN_SUB;
         end
         ST_BR_TAKE: begin
            ctrl.bsel   = BSEL_SEXT_SH;
            ctrl.fn     = FN_ADD;
            ctrl.pc_ld  = 1'b1;
            ctrl.pc_src = PCS_ALU;
         end
         ST_RR_EXE: begin
            ctrl.a_from_reg = 1'b1;
            ctrl.bsel       = BSEL_REG;
            ctrl.fn         = FN_FUNCT;
            ctrl.s_ld       = 1'b1;
         end
         ST_RR_WB: begin
            ctrl.rf_wr     = 1'b1;
            ctrl.rf_dst_rd = 1'b1;
         end
         ST_OI_EXE: begin
            ctrl.a_from_reg = 1'b1;
            ctrl.bsel       = BSEL_ZEXT;
            ctrl.fn         = FN_OR;
            ctrl.s_ld       = 1'b1;
         end
         ST_OI_WB: begin
            ctrl.rf_wr = 1'b1;
         end
         ST_LD_ADR, ST_ST_ADR: begin
            ctrl.a_from_reg = 1'b1;
            ctrl.bsel       = BSEL_SEXT;
            ctrl.fn         = FN_ADD;
            ctrl.s_ld       = 1'b1;
         end
         ST_LD_MEM: begin
            ctrl.mem_rd    = 1'b1;
            ctrl.mem_adr_s = 1'b1;
            ctrl.m_ld      = 1'b1;
         end
         ST_LD_WB: begin
            ctrl.rf_wr     = 1'b1;
            ctrl.rf_from_m = 1'b1;
         end
         ST_ST_MEM: begin
            ctrl.mem_wr    = 1'b1;
            ctrl.mem_adr_s = 1'b1;
         end
         ST_TRAP_UND, ST_TRAP_OVF: begin
            ctrl.bsel     = BSEL_FOUR;
            ctrl.fn       = FN_SUB;
            ctrl.epc_wr   = 1'b1;
            ctrl.cause_wr = 1'b1;
            ctrl.trap_ovf = (cur == ST_TRAP_OVF);
            ctrl.pc_ld    = 1'b1;
            ctrl.pc_src   = PCS_VEC;
         end
         ST_JUMP: begin
            ctrl.pc_ld  = 1'b1;
            ctrl.pc_src = PCS_JUMP;
         end
         default: ctrl = '0;
      endcase
   end

   always_comb begin
      if (!ctrl.cause_wr)     cause_val = '0;
      else if (ctrl.trap_ovf) cause_val = CAUSE_OVF;
      else                    cause_val = CAUSE_UNDEF;
   end

endmodule

// File: rtl/mcyc_seq_ctrl.sv
module mcyc_seq_ctrl
   import mcyc_pkg::*;
#(
   parameter int unsigned          OP_W       = 6,
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          CAUSE_W    = 32,
   parameter int unsigned          CODE_LSB   = 2,
   parameter int unsigned          CODE_W     = 4,
   parameter int unsigned          CODE_UNDEF = 10,
   parameter int unsigned          CODE_OVF   = 12,
   parameter logic [ADDR_W-1:0]    EXC_VECTOR = 32'h8000_0080,
   parameter logic [OP_W-1:0]      OP_RTYPE   = 6'h00,
   parameter logic [OP_W-1:0]      OP_LW      = 6'h23,
   parameter logic [OP_W-1:0]      OP_SW      = 6'h2B,
   parameter logic [OP_W-1:0]      OP_BEQ     = 6'h04,
   parameter logic [OP_W-1:0]      OP_ORI     = 6'h0D,
   parameter logic [OP_W-1:0]      OP_JMP     = 6'h02,
   parameter bit                   ONE_HOT    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OP_W-1:0]    opcode_i,
   input  logic               alu_eq_i,
   input  logic               alu_ovf_i,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               mem_adr_sel_o,
   output logic               ir_ld_o,
   output logic               ab_ld_o,
   output logic               s_ld_o,
   output logic               mdr_ld_o,
   output logic               alu_a_sel_o,
   output logic [2:0]         alu_b_sel_o,
   output logic [1:0]         alu_fn_o,
   output logic               reg_wr_o,
   output logic               reg_dst_sel_o,
   output logic               reg_wdata_sel_o,
   output logic               pc_ld_o,
   output logic [1:0]         pc_src_o,
   output logic               epc_wr_o,
   output logic               cause_wr_o,
   output logic [CAUSE_W-1:0] cause_val_o,
   output logic [ADDR_W-1:0]  exc_vec_o
);

   localparam int unsigned CODE_LIMIT = 1 << CODE_W;

   // elaboration-time parameter checks
   if (CODE_LSB + CODE_W > CAUSE_W) begin : g_bad_field
      $error("cause code field does not fit the cause word");
   end
   if (CODE_UNDEF >= CODE_LIMIT || CODE_OVF >= CODE_LIMIT) begin : g_bad_code
      $error("a cause code exceeds its field width");
   end
   if (CODE_UNDEF == CODE_OVF) begin : g_same_code
      $error("the two trap causes must differ");
   end
   if (OP_RTYPE == OP_LW || OP_RTYPE == OP_SW || OP_RTYPE == OP_BEQ ||
       OP_RTYPE == OP_ORI || OP_RTYPE == OP_JMP || OP_LW == OP_SW ||
       OP_LW == OP_BEQ || OP_LW == OP_ORI || OP_LW == OP_JMP ||
       OP_SW == OP_BEQ || OP_SW == OP_ORI || OP_SW == OP_JMP ||
       OP_BEQ == OP_ORI || OP_BEQ == OP_JMP || OP_ORI == OP_JMP) begin : g_dup_op
      $error("opcode assignments must be distinct");
   end

   op_class_e  op_class;
   seq_state_e cur_st;
   seq_state_e nxt_st;
   ctrl_t      ctrl;

   mcyc_op_classify #(
      .OP_W    (OP_W),
      .OP_RTYPE(OP_RTYPE),
      .OP_LW   (OP_LW),
      .OP_SW   (OP_SW),
      .OP_BEQ  (OP_BEQ),
      .OP_ORI  (OP_ORI),
      .OP_JMP  (OP_JMP)
   ) u_cls (
      .opcode  (opcode_i),
      .op_class(op_class)
   );

   mcyc_next_state u_nxt (
      .cur     (cur_st),
      .op_class(op_class),
      .alu_eq  (alu_eq_i),
      .alu_ovf (alu_ovf_i),
      .nxt     (nxt_st)
   );

   mcyc_state_store #(
      .ONE_HOT(ONE_HOT)
   ) u_st (
      .clk  (clk),
      .rst_n(rst_n),
      .nxt  (nxt_st),
      .cur  (cur_st)
   );

   mcyc_ctrl_decode #(
      .CAUSE_W   (CAUSE_W),
      .CODE_LSB  (CODE_LSB),
      .CODE_UNDEF(CODE_UNDEF),
      .CODE_OVF  (CODE_OVF)
   ) u_dec (
      .cur      (cur_st),
      .ctrl     (ctrl),
      .cause_val(cause_val_o)
   );

   assign mem_rd_o        = ctrl.mem_rd;
   assign mem_wr_o        = ctrl.mem_wr;
   assign mem_adr_sel_o   = ctrl.mem_adr_s;
   assign ir_ld_o         = ctrl.ir_ld;
   assign ab_ld_o         = ctrl.ab_ld;
   assign s_ld_o          = ctrl.s_ld;
   assign mdr_ld_o        = ctrl.m_ld;
   assign alu_a_sel_o     = ctrl.a_from_reg;
   assign alu_b_sel_o     = ctrl.bsel;
   assign alu_fn_o        = ctrl.fn;
   assign reg_wr_o        = ctrl.rf_wr;
   assign reg_dst_sel_o   = ctrl.rf_dst_rd;
   assign reg_wdata_sel_o = ctrl.rf_from_m;
   assign pc_ld_o         = ctrl.pc_ld;
   assign pc_src_o        = ctrl.pc_src;
   assign epc_wr_o        = ctrl.epc_wr;
   assign cause_wr_o      = ctrl.cause_wr;
   assign exc_vec_o       = EXC_VECTOR;

endmodule

// File: rtl/mcyc_seq_ctrl_chk.sv
module mcyc_seq_ctrl_chk
   import mcyc_pkg::*;
#(
   parameter int unsigned CAUSE_W  = 32,
   parameter int unsigned CODE_LSB = 2,
   parameter int unsigned CODE_OVF = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               alu_eq_i,
   input logic               alu_ovf_i,
   input logic               mem_rd_o,
   input logic               mem_wr_o,
   input logic               ir_ld_o,
   input logic               ab_ld_o,
   input logic               mdr_ld_o,
   input logic               alu_a_sel_o,
   input logic [2:0]         alu_b_sel_o,
   input logic [1:0]         alu_fn_o,
   input logic               reg_wr_o,
   input logic               reg_dst_sel_o,
   input logic               reg_wdata_sel_o,
   input logic               pc_ld_o,
   input logic [1:0]         pc_src_o,
   input logic               epc_wr_o,
   input logic               cause_wr_o,
   input logic [CAUSE_W-1:0] cause_val_o
);

   localparam logic [CAUSE_W-1:0] OVF_WORD = CAUSE_W'(CODE_OVF) << CODE_LSB;

   a_r1_reset_fetch: assert property (@(posedge clk)
      !rst_n |-> (ir_ld_o && pc_ld_o && mem_rd_o && !epc_wr_o));

   a_r2_decode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ir_ld_o |=> ab_ld_o);

   a_r3_rr_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_fn_o == FN_FUNCT && !alu_ovf_i) |=> (reg_wr_o && reg_dst_sel_o));

   a_r10_ovf_traps: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_fn_o == FN_FUNCT && alu_ovf_i) |=> (epc_wr_o && cause_val_o == OVF_WORD));

   a_r10_no_wb_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (epc_wr_o && cause_val_o == OVF_WORD) |=> !reg_wr_o);

   a_r5_load_writes_m: assert property (@(posedge clk) disable iff (!rst_n)
      mdr_ld_o |=> (reg_wr_o && reg_wdata_sel_o));

   a_r7_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_fn_o == FN_SUB && alu_a_sel_o && alu_eq_i)
      |=> (pc_ld_o && pc_src_o == PCS_ALU && alu_b_sel_o == BSEL_SEXT_SH));

   a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_fn_o == FN_SUB && alu_a_sel_o && !alu_eq_i) |=> ir_ld_o);

   a_r8_jump_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld_o && pc_src_o == PCS_JUMP) |=> ir_ld_o);

   a_r9_trap_returns: assert property (@(posedge clk) disable iff (!rst_n)
      epc_wr_o |=> ir_ld_o);

   a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   a_r12_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr_o |-> (cause_val_o == '0));

endmodule

bind mcyc_seq_ctrl mcyc_seq_ctrl_chk #(
   .CAUSE_W (CAUSE_W),
   .CODE_LSB(CODE_LSB),
   .CODE_OVF(CODE_OVF)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alu_eq_i       (alu_eq_i),
   .alu_ovf_i      (alu_ovf_i),
   .mem_rd_o       (mem_rd_o),
   .mem_wr_o       (mem_wr_o),
   .ir_ld_o        (ir_ld_o),
   .ab_ld_o        (ab_ld_o),
   .mdr_ld_o       (mdr_ld_o),
   .alu_a_sel_o    (alu_a_sel_o),
   .alu_b_sel_o    (alu_b_sel_o),
   .alu_fn_o       (alu_fn_o),
   .reg_wr_o       (reg_wr_o),
   .reg_dst_sel_o  (reg_dst_sel_o),
   .reg_wdata_sel_o(reg_wdata_sel_o),
   .pc_ld_o        (pc_ld_o),
   .pc_src_o       (pc_src_o),
   .epc_wr_o       (epc_wr_o),
   .cause_wr_o     (cause_wr_o),
   .cause_val_o    (cause_val_o)
);

// File: tb/mcyc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module mcyc_seq_ctrl_tb;

   localparam int VW = 85;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [5:0]  opcode_i = 6'h3F;
   logic        alu_eq_i = 1'b0;
   logic        alu_ovf_i = 1'b0;
   logic        mem_rd_o, mem_wr_o, mem_adr_sel_o, ir_ld_o, ab_ld_o, s_ld_o, mdr_ld_o;
   logic        alu_a_sel_o;
   logic [2:0]  alu_b_sel_o;
   logic [1:0]  alu_fn_o;
   logic        reg_wr_o, reg_dst_sel_o, reg_wdata_sel_o, pc_ld_o;
   logic [1:0]  pc_src_o;
   logic        epc_wr_o, cause_wr_o;
   logic [31:0] cause_val_o, exc_vec_o;

   int    n_vec = 0;
   int    n_bad = 0;
   int    m_st  = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string xtag = "";

   always #5 clk = ~clk;

   mcyc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .alu_eq_i(alu_eq_i),
      .alu_ovf_i(alu_ovf_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
      .mem_adr_sel_o(mem_adr_sel_o), .ir_ld_o(ir_ld_o), .ab_ld_o(ab_ld_o),
      .s_ld_o(s_ld_o), .mdr_ld_o(mdr_ld_o), .alu_a_sel_o(alu_a_sel_o),
      .alu_b_sel_o(alu_b_sel_o), .alu_fn_o(alu_fn_o), .reg_wr_o(reg_wr_o),
      .reg_dst_sel_o(reg_dst_sel_o), .reg_wdata_sel_o(reg_wdata_sel_o),
      .pc_ld_o(pc_ld_o), .pc_src_o(pc_src_o), .epc_wr_o(epc_wr_o),
      .cause_wr_o(cause_wr_o), .cause_val_o(cause_val_o), .exc_vec_o(exc_vec_o)
   );

   // reference model: step numbers as in the requirements
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_st <= 0;
      else begin
         case (m_st)
            0: m_st <= 1;
            1: begin
               if      (opcode_i == 6'h00) m_st <= 4;
               else if (opcode_i == 6'h23) m_st <= 8;
               else if (opcode_i == 6'h2B) m_st <= 11;
               else if (opcode_i == 6'h04) m_st <= 2;
               else if (opcode_i == 6'h0D) m_st <= 6;
               else if (opcode_i == 6'h02) m_st <= 15;
               else                        m_st <= 13;
            end
            2: m_st <= alu_eq_i ? 3 : 0;
            4: m_st <= alu_ovf_i ? 14 : 5;
            6: m_st <= 7;
            8: m_st <= 9;
            9: m_st <= 10;
            11: m_st <= 12;
            default: m_st <= 0;
         endcase
      end
   end

   function automatic logic [VW-1:0] exp_of(int s);
      logic mr = 0, mw = 0, adr = 0, ir = 0, ab = 0, sl = 0, ml = 0, a = 0;
      logic [2:0] bs = 0;
      logic [1:0] fn = 0;
      logic rw = 0, rd = 0, rm = 0, pl = 0;
      logic [1:0] ps = 0;
      logic ew = 0, cw = 0;
      logic [31:0] cv = 0;
      case (s)
         0: begin mr = 1; ir = 1; bs = 1; pl = 1; end
         1: ab = 1;
         2: begin a = 1; fn = 1; end
         3: begin bs = 3; pl = 1; end
         4: begin a = 1; fn = 2; sl = 1; end
         5: begin rw = 1; rd = 1; end
         6: begin a = 1; bs = 4; fn = 3; sl = 1; end
         7: rw = 1;
         8, 11: begin a = 1; bs = 2; sl = 1; end
         9: begin mr = 1; adr = 1; ml = 1; end
         10: begin rw = 1; rm = 1; end
         12: begin mw = 1; adr = 1; end
         13: begin bs = 1; fn = 1; ew = 1; cw = 1; pl = 1; ps = 2; cv = 32'h28; end
         14: begin bs = 1; fn = 1; ew = 1; cw = 1; pl = 1; ps = 2; cv = 32'h30; end
         15: begin pl = 1; ps = 1; end
         default: ;
      endcase
      return {mr, mw, adr, ir, ab, sl, ml, a, bs, fn, rw, rd, rm, pl, ps, ew, cw, cv,
              32'h8000_0080};
   endfunction

   function automatic string req_of(int s, bit in_rst);
      if (in_rst) return "R1";
      case (s)
         0: return "R1";
         1: return "R2";
         2, 3: return "R7";
         4, 5: return "R3";
         6, 7: return "R4";
         8, 9, 10: return "R5";
         11, 12: return "R6";
         13: return "R9";
         14: return "R10";
         default: return "R8";
      endcase
   endfunction

   always @(negedge clk) begin
      if (chk_on) begin
         logic [VW-1:0] got;
         logic [VW-1:0] exp;
         got = {mem_rd_o, mem_wr_o, mem_adr_sel_o, ir_ld_o, ab_ld_o, s_ld_o, mdr_ld_o,
                alu_a_sel_o, alu_b_sel_o, alu_fn_o, reg_wr_o, reg_dst_sel_o,
                reg_wdata_sel_o, pc_ld_o, pc_src_o, epc_wr_o, cause_wr_o, cause_val_o,
                exc_vec_o};
         exp = exp_of(m_st);
         n_vec++;
         if (got !== exp) begin
            n_bad++;
            $display("FAIL %s%s step=%0d got=%h exp=%h", req_of(m_st, !rst_n), xtag,
                     m_st, got, exp);
         end
         // R12: exclusive memory strobes, quiet cause value
         if ((mem_rd_o && mem_wr_o) || (!cause_wr_o && cause_val_o != 0)) begin
            n_bad++;
            $display("FAIL R12 rd=%b wr=%b cause_wr=%b cause=%h expected exclusive and quiet",
                     mem_rd_o, mem_wr_o, cause_wr_o, cause_val_o);
         end
      end
   end

   // one instruction from fetch back to fetch; opcode scrambled outside decode (R11)
   task automatic issue(input logic [5:0] op, input logic eq, input logic ovf);
      int guard = 0;
      alu_eq_i  = eq;
      alu_ovf_i = ovf;
      do begin
         @(negedge clk);
         #1;
         opcode_i = (m_st == 1) ? op : ~op;
         guard++;
      end while (m_st != 0 && guard < 20);
   endtask

   function automatic logic [5:0] pick(int k);
      case (k % 8)
         0: return 6'h00;
         1: return 6'h23;
         2: return 6'h2B;
         3: return 6'h04;
         4: return 6'h0D;
         5: return 6'h02;
         6: return 6'h3F;
         default: return 6'h11;
      endcase
   endfunction

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      #1 rst_n = 1'b0;
      chk_on = 1'b1;
      repeat (3) @(negedge clk);            // R1 reset state checked here
      #2 rst_n = 1'b1;
      @(negedge clk);
      // directed: each instruction kind, flags quiet
      issue(6'h00, 0, 0);                   // R3
      issue(6'h0D, 0, 0);                   // R4
      issue(6'h23, 0, 0);                   // R5
      issue(6'h2B, 0, 0);                   // R6
      issue(6'h04, 1, 0);                   // R7 taken
      issue(6'h04, 0, 0);                   // R7 not taken
      issue(6'h02, 0, 0);                   // R8
      issue(6'h3F, 0, 0);                   // R9
      issue(6'h01, 0, 0);                   // R9 neighbour of jump
      issue(6'h00, 0, 1);                   // R10
      // coincident flags
      xtag = " R11";
      issue(6'h00, 1, 1);
      issue(6'h00, 1, 0);
      issue(6'h04, 1, 1);
      issue(6'h04, 0, 1);
      issue(6'h0D, 1, 1);
      issue(6'h23, 1, 1);
      issue(6'h02, 1, 1);
      xtag = "";
      // reset in the middle of a load (R1)
      alu_eq_i = 0; alu_ovf_i = 0;
      do begin
         @(negedge clk); #1;
         opcode_i = 6'h23;
      end while (m_st != 9);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // pseudo-random instruction stream
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         issue(pick(int'(lfsr[2:0])), lfsr[5], lfsr[9]);
      end
      chk_on = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule